// File: doc/BRIEF.md
# Agent-gated key register file

This block is a small memory-mapped register file that stores a 128-bit cipher key in four 32-bit words. It sits next to a cipher core and hands that core the whole key on a wide output bus. Every access on its single-cycle register bus carries a 5-bit agent number. The block uses that number to decide, on that access alone, whether the agent may read key words, write key words, or reprogram the masks that grant those rights.

Three 32-bit masks govern access. Each has one bit per agent, and the bit index equals the agent number:

- The read mask gates key reads.
- The write mask gates key writes.
- A fixed control mask decides who may rewrite the read and write masks.

Holding control rights gives no access to the key. The control mask has no write path, so no agent can widen its own rights.

Read data and the error flag are registered and appear in the cycle after the request. A write lands on the clock edge that samples it.

Top module: `keyvault_regs`

## Requirements
- R1: After reset, all key words are 0x00000000. The control mask is 0x00000010 (agent 4), the read mask is 0x00000002 (agent 1) and the write mask is 0x00000004 (agent 2). The response outputs are zero.
- R2: Key word k sits at byte offset 4*k (k = 0..3) and supplies bits 32k+31..32k of `key_out`. `key_out` shows the key words at all times, whatever the read mask holds, and a granted write appears on it right after the sampling edge.
- R3: A key write completes only when bit `req_agent` of the write mask is 1. A refused key write leaves the word unchanged and sets `rsp_err`.
- R4: A key read returns the word only when bit `req_agent` of the read mask is 1. A refused key read returns 0x00000000 with `rsp_err` set.
- R5: A write to the read mask (offset 0x14) or the write mask (offset 0x18) completes only when bit `req_agent` of the control mask is 1; otherwise the mask is unchanged and `rsp_err` is set. Control rights alone grant no key read or key write.
- R6: The control mask at offset 0x10 cannot be changed. Every write to it is dropped and sets `rsp_err`.
- R7: Any agent may read the control, read and write masks, with `rsp_err` low.
- R8: An offset of 0x1C, or any offset with its two low bits nonzero, reads as zero and sets `rsp_err`. A write there changes nothing.
- R9: `rsp_rdata` and `rsp_err` update one cycle after the request. `rsp_rdata` is zero after writes and idle cycles. `rsp_err` is high for exactly the cycle after each refused access and low after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Access request in this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_agent | input | 5 | Number of the requesting agent |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered refusal flag |
| key_out | output | 128 | Assembled key for the cipher core |

## Verification
The key and both masks are visible from outside, so a wrong internal value shows up quickly:

- A wrong key word appears on `key_out` in the cycle right after the offending edge.
- A wrong mask shows as a wrong `rsp_err` or `rsp_rdata` on the next access that consults it.
- A wrong mask also shows one cycle after an explicit mask read.

The bench therefore reads the masks back after every attempted privilege change. It follows each refused write with a read of the target, so that silent corruption cannot hide until later.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

  // Register class selected by a bus offset
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_KEY   = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_RDPOL = 3'd3,
    SEL_WRPOL = 3'd4
  } sel_e;

  // Outcome of the per-access permission check
  typedef struct packed {
    logic key_wr;
    logic key_rd;
    logic pol_rd;
    logic rdpol_wr;
    logic wrpol_wr;
    logic deny;
  } grant_t;

endpackage

// File: rtl/kv_decode.sv
module kv_decode
  import keyvault_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int KEY_WORDS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [$clog2(KEY_WORDS)-1:0] key_idx
);
  localparam int IDX_W  = $clog2(KEY_WORDS);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CTRL  = WORD_W'(KEY_WORDS);
  localparam logic [WORD_W-1:0] W_RDPOL = WORD_W'(KEY_WORDS + 1);
  localparam logic [WORD_W-1:0] W_WRPOL = WORD_W'(KEY_WORDS + 2);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign key_idx = word[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (word < W_CTRL)        sel = SEL_KEY;
      else if (word == W_CTRL)  sel = SEL_CTRL;
      else if (word == W_RDPOL) sel = SEL_RDPOL;
      else if (word == W_WRPOL) sel = SEL_WRPOL;
    end
  end
endmodule

// File: rtl/kv_policy_gate.sv
module kv_policy_gate
  import keyvault_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AGENT_W = 5
) (
  input  logic               req_en,
  input  logic               req_we,
  input  sel_e               sel,
  input  logic [AGENT_W-1:0] agent,
  input  logic [DATA_W-1:0]  rd_pol,
  input  logic [DATA_W-1:0]  wr_pol,
  input  logic [DATA_W-1:0]  ctrl_pol,
  output grant_t             grant
);
  logic rd_ok, wr_ok, ctl_ok;

  assign rd_ok  = rd_pol[agent];
  assign wr_ok  = wr_pol[agent];
  assign ctl_ok = ctrl_pol[agent];

  always_comb begin
    grant = '0;
    if (req_en) begin
      unique case (sel)
        SEL_KEY: begin
          if (req_we) begin
            grant.key_wr = wr_ok;
            grant.deny   = !wr_ok;
          end else begin
            grant.key_rd = rd_ok;
            grant.deny   = !rd_ok;
          end
        end
        SEL_CTRL: begin
          if (req_we) grant.deny   = 1'b1;
          else        grant.pol_rd = 1'b1;
        end
        SEL_RDPOL: begin
          if (req_we) begin
            grant.rdpol_wr = ctl_ok;
            grant.deny     = !ctl_ok;
          end else begin
            grant.pol_rd = 1'b1;
          end
        end
        SEL_WRPOL: begin
          if (req_we) begin
            grant.wrpol_wr = ctl_ok;
            grant.deny     = !ctl_ok;
          end else begin
            grant.pol_rd = 1'b1;
          end
        end
        default: grant.deny = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/kv_key_store.sv
module kv_key_store #(
  parameter int DATA_W    = 32,
  parameter int KEY_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [$clog2(KEY_WORDS)-1:0] idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rd_word,
  output logic [KEY_WORDS*DATA_W-1:0]  key_flat
);
  localparam int IDX_W = $clog2(KEY_WORDS);

  logic [DATA_W-1:0] key_q [KEY_WORDS];

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                   key_q[w] <= '0;
      else if (wr_en && (idx == IDX_W'(w)))      key_q[w] <= wdata;
    end
    assign key_flat[w*DATA_W +: DATA_W] = key_q[w];
  end

  assign rd_word = key_q[idx];
endmodule

// File: rtl/kv_mask_reg.sv
module kv_mask_reg #(
  parameter int                 DATA_W  = 32,
  parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)     mask <= RST_VAL;
    else if (we) mask <= wdata;
  end
endmodule

// File: rtl/keyvault_regs.sv
module keyvault_regs
  import keyvault_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AGENT_W   = 5,
  parameter int ADDR_W    = 5,
  parameter int KEY_WORDS = 4,
  parameter logic [31:0] CTRL_RST  = 32'h0000_0010,
  parameter logic [31:0] RDPOL_RST = 32'h0000_0002,
  parameter logic [31:0] WRPOL_RST = 32'h0000_0004
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_en,
  input  logic                        req_we,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic [AGENT_W-1:0]          req_agent,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic                        rsp_err,
  output logic [KEY_WORDS*DATA_W-1:0] key_out
);
  localparam int IDX_W = $clog2(KEY_WORDS);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(CTRL_RST);

  sel_e              sel;
  logic [IDX_W-1:0]  key_idx;
  grant_t            grant;
  logic [DATA_W-1:0] rd_pol_q, wr_pol_q;
  logic [DATA_W-1:0] key_word;
  logic [DATA_W-1:0] rd_mux;

  kv_decode #(.ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS)) u_dec (
    .addr(req_addr), .sel(sel), .key_idx(key_idx)
  );

  kv_policy_gate #(.DATA_W(DATA_W), .AGENT_W(AGENT_W)) u_gate (
    .req_en(req_en), .req_we(req_we), .sel(sel), .agent(req_agent),
    .rd_pol(rd_pol_q), .wr_pol(wr_pol_q), .ctrl_pol(CTRL_MASK),
    .grant(grant)
  );

  kv_key_store #(.DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_keys (
    .clk(clk), .rst(rst), .wr_en(grant.key_wr), .idx(key_idx),
    .wdata(req_wdata), .rd_word(key_word), .key_flat(key_out)
  );

  kv_mask_reg #(.DATA_W(DATA_W), .RST_VAL(DATA_W'(RDPOL_RST))) u_rdpol (
    .clk(clk), .rst(rst), .we(grant.rdpol_wr), .wdata(req_wdata), .mask(rd_pol_q)
  );

  kv_mask_reg #(.DATA_W(DATA_W), .RST_VAL(DATA_W'(WRPOL_RST))) u_wrpol (
    .clk(clk), .rst(rst), .we(grant.wrpol_wr), .wdata(req_wdata), .mask(wr_pol_q)
  );

  // Only granted reads drive data; everything else returns zero
  always_comb begin
    rd_mux = '0;
    if (grant.key_rd) rd_mux = key_word;
    else if (grant.pol_rd) begin
      unique case (sel)
        SEL_CTRL:  rd_mux = CTRL_MASK;
        SEL_RDPOL: rd_mux = rd_pol_q;
        SEL_WRPOL: rd_mux = wr_pol_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rd_mux;
      rsp_err   <= grant.deny;
    end
  end
endmodule

// File: rtl/keyvault_regs_chk.sv
module keyvault_regs_chk #(
  parameter int DATA_W    = 32,
  parameter int AGENT_W   = 5,
  parameter int ADDR_W    = 5,
  parameter int KEY_WORDS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_en,
  input logic                        req_we,
  input logic [ADDR_W-1:0]           req_addr,
  input logic [AGENT_W-1:0]          req_agent,
  input logic [DATA_W-1:0]           rsp_rdata,
  input logic                        rsp_err,
  input logic [KEY_WORDS*DATA_W-1:0] key_out,
  input logic [DATA_W-1:0]           rd_pol,
  input logic [DATA_W-1:0]           wr_pol
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(KEY_WORDS * 4);
  localparam logic [ADDR_W-1:0] A_RDPOL = ADDR_W'(KEY_WORDS * 4 + 4);
  localparam logic [ADDR_W-1:0] A_WRPOL = ADDR_W'(KEY_WORDS * 4 + 8);

  logic is_key, is_pol;
  assign is_key = (req_addr < A_CTRL) && (req_addr[1:0] == 2'b00);
  assign is_pol = (req_addr == A_CTRL) || (req_addr == A_RDPOL) || (req_addr == A_WRPOL);

  // R3: refused key write leaves key_out untouched
  assert_key_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_we && is_key && !wr_pol[req_agent]) |=> ($stable(key_out) && rsp_err));

  // R4: refused key read returns zero with error
  assert_key_read_deny_R4: assert property (@(posedge clk) disable iff (rst)
    (req_en && !req_we && is_key && !rd_pol[req_agent]) |=> (rsp_err && rsp_rdata == '0));

  // R5: mask write without control right changes neither mask
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_we && (req_addr == A_RDPOL || req_addr == A_WRPOL) && !(req_agent == AGENT_W'(4)))
      |=> ($stable(rd_pol) && $stable(wr_pol) && rsp_err));

  // R6: control mask write always flagged
  assert_ctrl_write_err_R6: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_we && req_addr == A_CTRL) |=> rsp_err);

  // R7: mask reads never flagged
  assert_mask_read_ok_R7: assert property (@(posedge clk) disable iff (rst)
    (req_en && !req_we && is_pol) |=> !rsp_err);

  // R9: idle cycle yields quiet response
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_en |=> (!rsp_err && rsp_rdata == '0));

  // R2: key only moves after a key write
  assert_key_only_by_write_R2: assert property (@(posedge clk) disable iff (rst)
    !(req_en && req_we && is_key) |=> $stable(key_out));
endmodule

bind keyvault_regs keyvault_regs_chk #(
  .DATA_W(DATA_W), .AGENT_W(AGENT_W), .ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we), .req_addr(req_addr),
  .req_agent(req_agent), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .key_out(key_out), .rd_pol(rd_pol_q), .wr_pol(wr_pol_q)
);

// File: tb/tb_keyvault_regs.sv
module tb_keyvault_regs;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_en = 1'b0;
  logic         req_we = 1'b0;
  logic [4:0]   req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [4:0]   req_agent = '0;
  logic [31:0]  rsp_rdata;
  logic         rsp_err;
  logic [127:0] key_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  keyvault_regs dut (
    .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_agent(req_agent), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .key_out(key_out)
  );

  typedef struct {
    logic [31:0]  rdata;
    logic         err;
    logic [127:0] key;
    string        tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state built from the requirements
  logic [31:0] km [4];
  logic [31:0] rd_m, wr_m;
  localparam logic [31:0] CTRL_M = 32'h10;

  function automatic logic [127:0] key_model();
    return {km[3], km[2], km[1], km[0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [4:0] addr, input logic [31:0] wd,
                     input logic [4:0] ag, input string tag);
    exp_t e;
    int   idx;
    @(negedge clk);
    req_en = 1'b1; req_we = we; req_addr = addr; req_wdata = wd; req_agent = ag;
    e.rdata = '0; e.err = 1'b0; e.tag = tag;
    idx = int'(addr) >> 2;
    if (addr[1:0] != 2'b00 || idx > 6) begin
      e.err = 1'b1;
    end else if (idx < 4) begin
      if (we) begin
        if (wr_m[ag]) km[idx] = wd; else e.err = 1'b1;
      end else begin
        if (rd_m[ag]) e.rdata = km[idx]; else e.err = 1'b1;
      end
    end else if (idx == 4) begin
      if (we) e.err = 1'b1; else e.rdata = CTRL_M;
    end else begin
      if (we) begin
        if (CTRL_M[ag]) begin
          if (idx == 5) rd_m = wd; else wr_m = wd;
        end else e.err = 1'b1;
      end else e.rdata = (idx == 5) ? rd_m : wr_m;
    end
    e.key = key_model();
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    req_en = 1'b0; req_we = 1'b0;
    e.rdata = '0; e.err = 1'b0; e.key = key_model(); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops one expectation per cycle once results are out
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (!rst && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(rsp_err == e.err, e.tag, "rsp_err", 128'(rsp_err), 128'(e.err));
      chk(rsp_rdata == e.rdata, e.tag, "rsp_rdata", 128'(rsp_rdata), 128'(e.rdata));
      chk(key_out == e.key, e.tag, "key_out", key_out, e.key);
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) km[i] = '0;
    rd_m = 32'h2; wr_m = 32'h4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(key_out == '0, "R1", "reset key", key_out, '0);
    chk(rsp_rdata == '0, "R1", "reset rdata", 128'(rsp_rdata), '0);
    chk(rsp_err == 1'b0, "R1", "reset err", 128'(rsp_err), '0);
    acc(0, 5'h10, 0, 0, "R1");  // control mask
    acc(0, 5'h14, 0, 9, "R1");  // read mask
    acc(0, 5'h18, 0, 31, "R7"); // write mask, any agent
    acc(0, 5'h00, 0, 1, "R1");  // key word 0 is zero
    idle("R9");
    // R2/R3: agent 2 fills all key words
    acc(1, 5'h00, 32'h0123_4567, 2, "R2");
    acc(1, 5'h04, 32'h89AB_CDEF, 2, "R2");
    acc(1, 5'h08, 32'hDEAD_BEEF, 2, "R2");
    acc(1, 5'h0C, 32'hCAFE_F00D, 2, "R2");
    // R3: refused key writes by others
    acc(1, 5'h04, 32'h1111_1111, 3, "R3");
    acc(1, 5'h08, 32'h2222_2222, 1, "R3");
    // R5: control holder has no key rights
    acc(1, 5'h0C, 32'h3333_3333, 4, "R5");
    acc(0, 5'h0C, 0, 4, "R5");
    // R4: reads
    for (int k = 0; k < 4; k++) acc(0, 5'(k * 4), 0, 1, "R4");
    acc(0, 5'h00, 0, 2, "R4");
    acc(0, 5'h08, 0, 3, "R4");
    idle("R9");
    // R5: untrusted agent tries to grant itself write rights
    acc(1, 5'h18, 32'h0000_000C, 3, "R5");
    acc(0, 5'h18, 0, 3, "R5");
    acc(1, 5'h04, 32'h4444_4444, 3, "R5");
    // R5: control holder reprograms masks
    acc(1, 5'h18, 32'h0000_000C, 4, "R5");
    acc(1, 5'h04, 32'h5555_5555, 3, "R3");
    acc(1, 5'h14, 32'h0000_0001, 4, "R5");
    acc(0, 5'h04, 0, 0, "R4");
    acc(0, 5'h04, 0, 1, "R4");
    // R6: control mask is fixed
    acc(1, 5'h10, 32'hFFFF_FFFF, 4, "R6");
    acc(1, 5'h10, 32'h0000_0008, 3, "R6");
    acc(0, 5'h10, 0, 3, "R6");
    acc(1, 5'h18, 32'hFFFF_FFFF, 3, "R6");
    acc(0, 5'h18, 0, 5, "R6");
    // R8: unmapped and misaligned offsets
    acc(0, 5'h1C, 0, 0, "R8");
    acc(1, 5'h1C, 32'hFFFF_FFFF, 4, "R8");
    acc(1, 5'h02, 32'h6666_6666, 2, "R8");
    acc(0, 5'h01, 0, 0, "R8");
    acc(1, 5'h15, 32'hFFFF_FFFF, 4, "R8");
    acc(0, 5'h14, 0, 7, "R8");
    // R9: error pulses only once, then clears
    idle("R9");
    idle("R9");
    acc(0, 5'h0C, 0, 0, "R9");
    idle("R9");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule